// File: doc/BRIEF.md
# Three-Bus Fetch Datapath

This block is the fetch half of a small 32-bit processor datapath built around one two-input ALU. Registers may only drive the two ALU input buses (B1 and B2), and only the ALU output bus (B3) can write a register. With the operands and the result on separate buses, the ALU can route a value in one clock. It can also form PC+1 in one clock, with no holding registers in front of or behind it. The block holds the program counter, the memory address register, the memory buffer register and the instruction register. It also has an extender that turns the low 20 bits of the instruction into a 32-bit word, either zero-extended or sign-extended.

A three-phase sequencer runs the fetch. In T0 the PC passes through the ALU into the MAR and a read request is issued. In T1 the PC is incremented while memory is busy, and the returned word is captured in the MBR. In T2 the MBR passes through the ALU into the IR, and the sequence then returns to T0; the execute phase is a stub that is held idle.

The memory side uses two valid/ready streams. The read request is offered in T0, and the sequencer stays in T0 until `req_ready` is high on a clock edge. `rsp_ready` is high only in T1, and the sequencer waits there until `rsp_valid` arrives. A response offered outside T1 is never taken. Back-pressure on either stream only stretches the phase; nothing is repeated or lost.

Top module: `tribus_fetch_dp`

## Requirements
- R1: While `rst_n` is low, `phase` reads 0, `pc` reads the RESET_PC parameter, and `mar` and `ir` read zero.
- R2: In T0 (`phase`=0), `req_valid` is 1, B1 and B3 both carry the PC (ALU pass of B1), and `req_addr` equals B3. The MAR takes B3 on each T0 edge. The block stays in T0 while `req_ready` is low and moves to T1 on the first edge where it is high.
- R3: In T1 (`phase`=1), `rsp_ready` is 1, B1 carries the PC, B2 carries the constant 1, and B3 carries their sum. The block waits in T1 until `rsp_valid` is high. On that edge the PC takes B3 and the MBR takes `rsp_data`, and the block moves to T2. At no other time does the PC change.
- R4: In T2 (`phase`=2), B2 and B3 carry the MBR (ALU pass of B2). The IR takes B3 on that edge, and the next phase is T0.
- R5: The PC increment wraps modulo 2^32.
- R6: When `imm_sext` is low, `imm_word` is IR bits 19..0 with bits 31..20 zero.
- R7: When `imm_sext` is high, `imm_word` is IR bits 19..0 with bits 31..20 all copies of IR bit 19.
- R8: `rsp_valid` and `rsp_data` outside T1, and `req_ready` outside T0, have no effect on any register or on the phase.
- R9: Each bus has at most one enabled source per cycle. A bus with no enabled source reads zero (B1 in T2, B2 in T0).
- R10: The phase code runs 0, 1, 2 and back to 0, and holds only in T0 or T1 as described above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | output | 1 | Read request offered (T0) |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Read address (B3 in T0) |
| rsp_valid | input | 1 | Read data offered |
| rsp_ready | output | 1 | Read data accepted (T1) |
| rsp_data | input | 32 | Read data word |
| imm_sext | input | 1 | 1 selects sign extension of IR bits 19..0 |
| imm_word | output | 32 | Extended immediate |
| phase | output | 2 | Fetch phase code: 0 = T0, 1 = T1, 2 = T2 |
| pc | output | 32 | Program counter |
| mar | output | 32 | Memory address register |
| ir | output | 32 | Instruction register |
| bus_b1 | output | 32 | ALU input bus B1 |
| bus_b2 | output | 32 | ALU input bus B2 |
| bus_b3 | output | 32 | ALU output bus B3 |

## Verification
The fetch loop runs under four conditions: memory always ready with zero response latency, request stalls with `req_ready` dropped on a pattern, response latencies of one to three cycles, and stray responses with junk data injected outside T1. Comparing these runs separates a sequencer that counts phases from one that follows the handshakes. The junk responses show whether the MBR is guarded. Starting the PC three words below the top of the address space forces the increment to wrap. Fetched words alternate bit 19, and `imm_sext` is toggled on its own cadence, so every combination of sign bit and extend mode appears on `imm_word`.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
  typedef enum logic [1:0] {
    PH_T0 = 2'd0,
    PH_T1 = 2'd1,
    PH_T2 = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_TRA1 = 2'd1,
    OP_TRA2 = 2'd2
  } alu_op_e;

  // Source slots on each ALU input bus.
  localparam int B1_SRCS = 2;
  localparam int B1_PC   = 0;
  localparam int B1_IMM  = 1;
  localparam int B2_SRCS = 2;
  localparam int B2_ONE  = 0;
  localparam int B2_MBR  = 1;

  typedef struct packed {
    logic [B1_SRCS-1:0] b1_en;
    logic [B2_SRCS-1:0] b2_en;
    alu_op_e            op;
    logic               mar_we;
    logic               pc_we;
    logic               mbr_we;
    logic               ir_we;
    logic               req_valid;
    logic               rsp_ready;
  } ctrl_t;
endpackage

// File: rtl/tbf_alu.sv
module tbf_alu
  import tbf_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_TRA1: y = a;
      OP_TRA2: y = b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/tbf_bus_mux.sv
module tbf_bus_mux #(
  parameter int W = 32,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        en,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]        bus
);
  // AND-OR bus: an undriven bus reads zero.
  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) begin
      bus = bus | (src[i] & {W{en[i]}});
    end
  end

  a_r9_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en));
endmodule

// File: rtl/tbf_imm_ext.sv
module tbf_imm_ext #(
  parameter int W     = 32,
  parameter int IMM_W = 20
) (
  input  logic [IMM_W-1:0] field,
  input  logic             sext,
  output logic [W-1:0]     word
);
  localparam int PAD_W = W - IMM_W;

  generate
    if (PAD_W > 0) begin : g_pad
      logic fill;
      assign fill = sext & field[IMM_W-1];
      assign word = {{PAD_W{fill}}, field};
    end else begin : g_nopad
      assign word = field[W-1:0];
    end
  endgenerate
endmodule

// File: rtl/tbf_fetch_seq.sv
module tbf_fetch_seq
  import tbf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_ready,
  input  logic   rsp_valid,
  output phase_e phase,
  output ctrl_t  ctrl
);
  phase_e nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_T0;
    else        phase <= nxt;
  end

  always_comb begin
    ctrl = '0;
    nxt  = phase;
    unique case (phase)
      PH_T0: begin
        ctrl.b1_en[B1_PC] = 1'b1;
        ctrl.op           = OP_TRA1;
        ctrl.mar_we       = 1'b1;
        ctrl.req_valid    = 1'b1;
        if (req_ready) nxt = PH_T1;
      end
      PH_T1: begin
        ctrl.b1_en[B1_PC]  = 1'b1;
        ctrl.b2_en[B2_ONE] = 1'b1;
        ctrl.op            = OP_ADD;
        ctrl.rsp_ready     = 1'b1;
        if (rsp_valid) begin
          ctrl.pc_we  = 1'b1;
          ctrl.mbr_we = 1'b1;
          nxt         = PH_T2;
        end
      end
      PH_T2: begin
        ctrl.b2_en[B2_MBR] = 1'b1;
        ctrl.op            = OP_TRA2;
        ctrl.ir_we         = 1'b1;
        nxt                = PH_T0;
      end
      default: nxt = PH_T0;
    endcase
  end

  a_r10_t2_to_t0: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T2) |=> (phase == PH_T0));
  a_r2_hold_t0: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T0 && !req_ready) |=> (phase == PH_T0));
  a_r3_wait_t1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T1 && !rsp_valid) |=> (phase == PH_T1));
  a_r10_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd3));
endmodule

// File: rtl/tribus_fetch_dp.sv
module tribus_fetch_dp
  import tbf_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          IMM_W    = 20,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic         req_valid,
  input  logic         req_ready,
  output logic [W-1:0] req_addr,
  input  logic         rsp_valid,
  output logic         rsp_ready,
  input  logic [W-1:0] rsp_data,
  input  logic         imm_sext,
  output logic [W-1:0] imm_word,
  output logic [1:0]   phase,
  output logic [W-1:0] pc,
  output logic [W-1:0] mar,
  output logic [W-1:0] ir,
  output logic [W-1:0] bus_b1,
  output logic [W-1:0] bus_b2,
  output logic [W-1:0] bus_b3
);
  phase_e ph;
  ctrl_t  ctrl;

  logic [W-1:0] pc_q, mar_q, mbr_q, ir_q;
  logic [W-1:0] b1, b2, b3, imm_q;
  logic [B1_SRCS-1:0][W-1:0] b1_src;
  logic [B2_SRCS-1:0][W-1:0] b2_src;

  tbf_fetch_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .phase     (ph),
    .ctrl      (ctrl)
  );

  tbf_imm_ext #(.W(W), .IMM_W(IMM_W)) u_ext (
    .field (ir_q[IMM_W-1:0]),
    .sext  (imm_sext),
    .word  (imm_q)
  );

  always_comb begin
    b1_src[B1_PC]  = pc_q;
    b1_src[B1_IMM] = imm_q;
    b2_src[B2_ONE] = W'(1);
    b2_src[B2_MBR] = mbr_q;
  end

  tbf_bus_mux #(.W(W), .N(B1_SRCS)) u_b1 (
    .clk(clk), .rst_n(rst_n), .en(ctrl.b1_en), .src(b1_src), .bus(b1)
  );
  tbf_bus_mux #(.W(W), .N(B2_SRCS)) u_b2 (
    .clk(clk), .rst_n(rst_n), .en(ctrl.b2_en), .src(b2_src), .bus(b2)
  );

  tbf_alu #(.W(W)) u_alu (
    .op (ctrl.op),
    .a  (b1),
    .b  (b2),
    .y  (b3)
  );

  // Every register is written only from B3 or the memory stream.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= W'(RESET_PC);
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (ctrl.pc_we)  pc_q  <= b3;
      if (ctrl.mar_we) mar_q <= b3;
      if (ctrl.mbr_we) mbr_q <= rsp_data;
      if (ctrl.ir_we)  ir_q  <= b3;
    end
  end

  assign req_valid = ctrl.req_valid;
  assign req_addr  = b3;
  assign rsp_ready = ctrl.rsp_ready;
  assign imm_word  = imm_q;
  assign phase     = ph;
  assign pc        = pc_q;
  assign mar       = mar_q;
  assign ir        = ir_q;
  assign bus_b1    = b1;
  assign bus_b2    = b2;
  assign bus_b3    = b3;

  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T1 && rsp_valid) |=> (pc_q == $past(pc_q) + W'(1)));
  a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph == PH_T1 && rsp_valid) |=> $stable(pc_q));
  a_r8_mbr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph == PH_T1 && rsp_valid) |=> $stable(mbr_q));
  a_r4_ir_from_mbr: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T2) |=> (ir_q == $past(mbr_q)));
  a_r2_mar_from_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T0) |=> (mar_q == $past(pc_q)));
endmodule

// File: tb/tribus_fetch_dp_test.sv
module tribus_fetch_dp_test;
  localparam logic [31:0] START_PC = 32'hFFFF_FFFD;
  localparam int NCYC = 600;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, rsp_valid, rsp_ready, imm_sext;
  logic [31:0] req_addr, rsp_data, imm_word, pc, mar, ir, bus_b1, bus_b2, bus_b3;
  logic [1:0]  phase;

  int checks = 0;
  int errors = 0;

  // Reference model state.
  int          m_ph;
  logic [31:0] m_pc, m_mar, m_mbr, m_ir;
  int          cnt;
  int          lat;
  bit          junk_seen;

  always #5 clk = ~clk;

  tribus_fetch_dp #(.RESET_PC(START_PC)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .imm_sext(imm_sext), .imm_word(imm_word), .phase(phase),
    .pc(pc), .mar(mar), .ir(ir),
    .bus_b1(bus_b1), .bus_b2(bus_b2), .bus_b3(bus_b3)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] r;
    r = (a * 32'h2545_F491) ^ 32'h5A5A_0000;
    r[19] = a[0];
    return r;
  endfunction

  // Advance the model across one clock edge using the inputs held there.
  task automatic step();
    case (m_ph)
      0: begin
        m_mar = m_pc;
        if (req_ready) begin m_ph = 1; cnt = lat; end
      end
      1: begin
        if (rsp_valid) begin
          m_pc  = m_pc + 32'd1;
          m_mbr = rsp_data;
          m_ph  = 2;
        end else if (cnt > 0) cnt--;
      end
      default: begin
        m_ir = m_mbr;
        m_ph = 0;
      end
    endcase
  endtask

  task automatic drive(input int cyc);
    lat      = (cyc < 150) ? 0 : ((cyc < 300) ? 1 + (cyc % 3) : 2);
    req_ready = (cyc >= 150 && cyc < 450) ? ((cyc % 5) != 3) : 1'b1;
    imm_sext = cyc[1];
    if (m_ph == 1) begin
      rsp_valid = (cnt == 0);
      rsp_data  = mem_word(m_mar);
    end else if (cyc >= 300 && (cyc % 3) == 0) begin
      rsp_valid = 1'b1;               // stray response, must be ignored
      rsp_data  = 32'hDEAD_BEEF ^ cyc;
      junk_seen = 1'b1;
    end else begin
      rsp_valid = 1'b0;
      rsp_data  = 32'h0;
    end
  endtask

  task automatic compare();
    logic [31:0] e_b1, e_b2, e_b3, e_imm;
    string rq;
    e_b1 = (m_ph == 2) ? 32'h0 : m_pc;
    e_b2 = (m_ph == 0) ? 32'h0 : ((m_ph == 1) ? 32'd1 : m_mbr);
    e_b3 = (m_ph == 0) ? m_pc : ((m_ph == 1) ? m_pc + 32'd1 : m_mbr);
    e_imm = {(imm_sext && m_ir[19]) ? 12'hFFF : 12'h000, m_ir[19:0]};
    chk("R10", "phase", 32'(phase), 32'(m_ph));
    chk("R2", "req_valid", 32'(req_valid), 32'(m_ph == 0));
    chk("R3", "rsp_ready", 32'(rsp_ready), 32'(m_ph == 1));
    chk((m_ph == 2) ? "R9" : "R2", "bus_b1", bus_b1, e_b1);
    chk((m_ph == 0) ? "R9" : "R3", "bus_b2", bus_b2, e_b2);
    rq = (m_ph == 2) ? (junk_seen ? "R8" : "R4") : ((m_ph == 1) ? "R3" : "R2");
    chk(rq, "bus_b3", bus_b3, e_b3);
    if (m_ph == 0) chk("R2", "req_addr", req_addr, m_pc);
    chk((m_pc < 32'h10) ? "R5" : "R3", "pc", pc, m_pc);
    chk("R2", "mar", mar, m_mar);
    chk(junk_seen ? "R8" : "R4", "ir", ir, m_ir);
    chk(imm_sext ? "R7" : "R6", "imm_word", imm_word, e_imm);
  endtask

  initial begin
    #(10 * 250000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_ready = 1'b1; rsp_valid = 1'b1;
    rsp_data = 32'hFFFF_FFFF; imm_sext = 1'b1;
    m_ph = 0; m_pc = START_PC; m_mar = 0; m_mbr = 0; m_ir = 0;
    cnt = 0; lat = 0; junk_seen = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "phase", 32'(phase), 32'd0);
    chk("R1", "pc", pc, START_PC);
    chk("R1", "mar", mar, 32'h0);
    chk("R1", "ir", ir, 32'h0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      drive(cyc);
      #1;
      compare();
      @(negedge clk);
      step();
    end
    // R5: the counter passed through the top of the address space.
    chk("R5", "pc wrapped", 32'(m_pc < START_PC), 32'd1);
    chk("R5", "pc", pc, m_pc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule